// File: doc/BRIEF.md
# Read-only NAND-style page front end

This block sits on the device side of a read-only memory reached over an eight-bit multiplexed bus. The host sends a command byte while the command-latch strobe is high and address bytes while the address-latch strobe is high. Each byte is taken on the rising edge of the write strobe. A read command followed by three address bytes names a page: one column byte, then two row bytes holding a 5-bit page index and an 11-bit block index. The block then copies the 512 data bytes of that page from a synchronous backing array into a local page buffer, holding ready/busy low while it does so. Successive read-strobe pulses then stream the page out.

Each page has 16 spare bytes after its data bytes. They are never fetched and always read as FFh. When a sequential read moves past the last spare byte, the block moves to the next row on its own and reopens the busy window. The host can also read a status byte, which is available even in the middle of a load, and a two-byte identifier. A reset command returns the block to idle. Raising chip enable during a read abandons it at once. Nothing is ever written into the array.

Inputs are sampled on the block clock, so the bus strobes must each stay at a level for at least two clock cycles.

Top module: `nand_rom_front`

## Requirements
- R1: With `ce_n` low, a rising edge of `we_n` latches `io_in` as a command when `cle`=1 and `ale`=0, and as an address byte when `ale`=1 and `cle`=0. Strobe edges seen while `ce_n` is high have no effect. A read takes three address bytes: column, row bits 7:0, row bits 15:8. The row is {block[10:0], page[4:0]}.
- R2: Command 00h starts streaming at the column given by the column byte. Command 01h starts at 256 plus that byte. Command 50h starts at 512 plus the byte's low four bits.
- R3: After the third address byte, `rdy` is low in the first sampled cycle. It stays low for exactly LOAD_BUSY = max(LOAD_CYCLES, PAGE_BYTES+ARR_LAT+1) cycles (560 by default). During that time the array is read at address {row, column[8:0]} for every data column, and `arr_rdata` is taken ARR_LAT cycles after `arr_en`.
- R4: In the stream, `io_out` shows the byte at the current column while `re_n` is low. Each rising edge of `re_n` moves to the next column.
- R5: Columns 512 to 527 always read FFh, whatever the array holds.
- R6: The rising edge of `re_n` at column 527 drops `rdy` for another LOAD_BUSY cycles and loads row+1. Streaming then restarts at column 0 after 00h or 01h, and at column 512 after 50h.
- R7: Taking `ce_n` high during address entry, a load or a stream returns `rdy` high by the next cycle and leaves the block idle. An idle data read returns FFh.
- R8: Command 70h selects the status byte without disturbing a load in progress. The status byte is 80h while busy and C0h while ready: bit 7 = 1, bit 6 = ready, all other bits 0.
- R9: Command 90h makes the next two `re_n` pulses return ID_MAKER (A7h) and then ID_DEVICE (3Ch). Any further reads return FFh.
- R10: Command FFh is accepted in any state, including during a load. It holds `rdy` low for exactly RST_CYCLES (24) cycles and then leaves the block idle.
- R11: `io_oe` is 1 only while `ce_n` is low and `re_n` is low.
- R12: Command codes other than 00h, 01h, 50h, 70h, 90h and FFh (for example the program codes 80h and 10h) are ignored. A stream resumes at the same column after them.
- R13: After reset, `rdy` is 1 and `io_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks the bus byte as a command |
| ale | input | 1 | Marks the bus byte as an address byte |
| we_n | input | 1 | Write strobe; its rising edge takes the bus byte |
| re_n | input | 1 | Read strobe; low shows a byte, its rising edge advances |
| io_in | input | 8 | Bus byte from the host |
| io_out | output | 8 | Bus byte to the host |
| io_oe | output | 1 | Output enable for the bus pads |
| rdy | output | 1 | 1 = ready, 0 = busy |
| arr_en | output | 1 | Backing array read request |
| arr_addr | output | 25 | Backing array byte address {row, column} |
| arr_rdata | input | 8 | Backing array data, ARR_LAT cycles after the request |

## Verification
The hardest case to reach is the automatic reload at the page boundary. From the ports it needs a read that starts late in a page and then enough pulses to walk off the last spare byte. The stimulus does this with a 01h read at a high column and a 50h read near the end of the spare area. It then measures the second busy window and checks the first bytes of row+1 at the restart column. A status read issued during a load, and a reset issued during a load, are also driven deliberately so that both interrupts meet a busy loader.

// File: rtl/nand_rom_pkg.sv
package nand_rom_pkg;

  typedef enum logic [1:0] {RM_LOW, RM_HIGH, RM_SPARE} rd_mode_e;
  typedef enum logic [1:0] {OM_DATA, OM_STATUS, OM_ID} out_mode_e;
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LOAD, S_STREAM, S_RESET} seq_state_e;

  localparam logic [7:0] CMD_RD_LOW   = 8'h00;
  localparam logic [7:0] CMD_RD_HIGH  = 8'h01;
  localparam logic [7:0] CMD_RD_SPARE = 8'h50;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_RESET    = 8'hFF;

  // first column streamed after the address phase
  function automatic logic [15:0] start_col(rd_mode_e m, logic [7:0] c, int unsigned page_bytes);
    case (m)
      RM_HIGH:  return 16'(page_bytes / 2) + {8'd0, c};
      RM_SPARE: return 16'(page_bytes) + {12'd0, c[3:0]};
      default:  return {8'd0, c};
    endcase
  endfunction

  // column streamed first after an automatic page crossing
  function automatic logic [15:0] wrap_col(rd_mode_e m, int unsigned page_bytes);
    return (m == RM_SPARE) ? 16'(page_bytes) : 16'd0;
  endfunction

  function automatic logic [7:0] status_byte(logic ready);
    return {1'b1, ready, 6'd0};
  endfunction

  function automatic logic is_read_cmd(logic [7:0] c);
    return (c == CMD_RD_LOW) || (c == CMD_RD_HIGH) || (c == CMD_RD_SPARE);
  endfunction

endpackage

// File: rtl/nand_rom_edge.sv
module nand_rom_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= pin;
  end

  assign rise = pin & ~q;
  assign fall = ~pin & q;
endmodule

// File: rtl/nand_rom_loader.sv
module nand_rom_loader #(
  parameter int PAGE_BYTES  = 512,
  parameter int ROW_W       = 16,
  parameter int ARR_LAT     = 2,
  parameter int LOAD_CYCLES = 560,
  parameter int RST_CYCLES  = 24
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_load,
  input  logic                                  start_rst,
  input  logic                                  abort,
  input  logic [ROW_W-1:0]                      row,
  output logic                                  arr_en,
  output logic [ROW_W+$clog2(PAGE_BYTES)-1:0]   arr_addr,
  input  logic [7:0]                            arr_rdata,
  input  logic [$clog2(PAGE_BYTES)-1:0]         rd_col,
  output logic [7:0]                            rd_data,
  output logic                                  busy,
  output logic                                  done
);
  localparam int DCOL_W    = $clog2(PAGE_BYTES);
  localparam int FILL_MIN  = PAGE_BYTES + ARR_LAT + 1;
  localparam int LOAD_BUSY = (LOAD_CYCLES > FILL_MIN) ? LOAD_CYCLES : FILL_MIN;
  localparam int MAX_BUSY  = (LOAD_BUSY > RST_CYCLES) ? LOAD_BUSY : RST_CYCLES;
  localparam int CNT_W     = $clog2(MAX_BUSY + 1);

  logic [CNT_W-1:0]  cnt, lim;
  logic              active, fill;
  logic [ROW_W-1:0]  row_q;
  logic [ARR_LAT-1:0] pv;
  logic [DCOL_W-1:0] pidx [ARR_LAT];
  logic [7:0]        page_mem [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      fill   <= 1'b0;
      cnt    <= '0;
      lim    <= '0;
      row_q  <= '0;
    end else if (start_rst) begin
      active <= 1'b1;
      fill   <= 1'b0;
      cnt    <= '0;
      lim    <= CNT_W'(RST_CYCLES);
    end else if (abort) begin
      active <= 1'b0;
    end else if (start_load) begin
      active <= 1'b1;
      fill   <= 1'b1;
      cnt    <= '0;
      lim    <= CNT_W'(LOAD_BUSY);
      row_q  <= row;
    end else if (active) begin
      if (cnt == lim - CNT_W'(1)) active <= 1'b0;
      else                        cnt    <= cnt + CNT_W'(1);
    end
  end

  assign done     = active && !abort && !start_rst && (cnt == lim - CNT_W'(1));
  assign busy     = active;
  assign arr_en   = active && fill && (32'(cnt) < PAGE_BYTES);
  assign arr_addr = {row_q, cnt[DCOL_W-1:0]};

  // return path: request tags travel ARR_LAT stages beside the array latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < ARR_LAT; i++) pidx[i] <= '0;
    end else begin
      pv[0]   <= arr_en && !abort && !start_rst;
      pidx[0] <= cnt[DCOL_W-1:0];
      for (int i = 1; i < ARR_LAT; i++) begin
        pv[i]   <= pv[i-1];
        pidx[i] <= pidx[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pv[ARR_LAT-1]) page_mem[pidx[ARR_LAT-1]] <= arr_rdata;
  end

  assign rd_data = page_mem[rd_col];
endmodule

// File: rtl/nand_rom_seq.sv
module nand_rom_seq
  import nand_rom_pkg::*;
#(
  parameter int PAGE_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ROW_W       = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     ce_n,
  input  logic                                     cle,
  input  logic                                     ale,
  input  logic [7:0]                               io_in,
  input  logic                                     we_rise,
  input  logic                                     re_rise,
  input  logic                                     done,
  output logic                                     start_load,
  output logic                                     start_rst,
  output logic                                     abort,
  output logic                                     page_cross,
  output logic [ROW_W-1:0]                         load_row,
  output logic [$clog2(PAGE_BYTES+SPARE_BYTES)-1:0] col_q,
  output seq_state_e                               state_q,
  output out_mode_e                                omode_q,
  output logic [1:0]                               id_idx_q
);
  localparam int TOTAL  = PAGE_BYTES + SPARE_BYTES;
  localparam int TCOL_W = $clog2(TOTAL);

  rd_mode_e         mode_q;
  logic [1:0]       acnt_q;
  logic [7:0]       colb_q, rowlo_q;
  logic [ROW_W-1:0] row_q;
  logic             cmd_ev, addr_ev, adv_ev, last_col, addr_done;

  assign cmd_ev    = !ce_n && we_rise && cle && !ale;
  assign addr_ev   = !ce_n && we_rise && ale && !cle;
  assign adv_ev    = !ce_n && re_rise;
  assign last_col  = (col_q == TCOL_W'(TOTAL - 1));
  assign addr_done = addr_ev && (state_q == S_ADDR) && (acnt_q == 2'd2);

  assign start_rst  = cmd_ev && (io_in == CMD_RESET);
  assign abort      = ce_n && (state_q inside {S_ADDR, S_LOAD, S_STREAM});
  assign page_cross = adv_ev && (state_q == S_STREAM) && (omode_q == OM_DATA) && last_col;
  assign start_load = !start_rst && (addr_done || page_cross);
  assign load_row   = (state_q == S_ADDR) ? ROW_W'({io_in, rowlo_q}) : row_q + ROW_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      omode_q  <= OM_DATA;
      mode_q   <= RM_LOW;
      acnt_q   <= '0;
      colb_q   <= '0;
      rowlo_q  <= '0;
      row_q    <= '0;
      col_q    <= '0;
      id_idx_q <= '0;
    end else if (start_rst) begin
      state_q <= S_RESET;
      omode_q <= OM_DATA;
    end else if (abort) begin
      state_q <= S_IDLE;
    end else begin
      if (cmd_ev) begin
        if (io_in == CMD_STATUS) begin
          omode_q <= OM_STATUS;
        end else if (state_q != S_LOAD && state_q != S_RESET) begin
          if (is_read_cmd(io_in)) begin
            mode_q  <= (io_in == CMD_RD_HIGH)  ? RM_HIGH :
                       (io_in == CMD_RD_SPARE) ? RM_SPARE : RM_LOW;
            state_q <= S_ADDR;
            acnt_q  <= '0;
            omode_q <= OM_DATA;
          end else if (io_in == CMD_IDENT) begin
            omode_q  <= OM_ID;
            id_idx_q <= '0;
            state_q  <= S_IDLE;
          end
        end
      end
      if (addr_ev && state_q == S_ADDR) begin
        acnt_q <= acnt_q + 2'd1;
        case (acnt_q)
          2'd0:    colb_q  <= io_in;
          2'd1:    rowlo_q <= io_in;
          default: begin
            row_q   <= load_row;
            col_q   <= TCOL_W'(start_col(mode_q, colb_q, PAGE_BYTES));
            state_q <= S_LOAD;
          end
        endcase
      end
      if (done && state_q == S_LOAD)  state_q <= S_STREAM;
      if (done && state_q == S_RESET) state_q <= S_IDLE;
      if (adv_ev) begin
        if (page_cross) begin
          col_q   <= TCOL_W'(wrap_col(mode_q, PAGE_BYTES));
          row_q   <= load_row;
          state_q <= S_LOAD;
        end else if (state_q == S_STREAM && omode_q == OM_DATA) begin
          col_q <= col_q + TCOL_W'(1);
        end
        if (omode_q == OM_ID && id_idx_q != 2'd2) id_idx_q <= id_idx_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/nand_rom_front.sv
module nand_rom_front
  import nand_rom_pkg::*;
#(
  parameter int         PAGE_BYTES  = 512,
  parameter int         SPARE_BYTES = 16,
  parameter int         PAGE_BITS   = 5,
  parameter int         BLOCK_BITS  = 11,
  parameter int         ARR_LAT     = 2,
  parameter int         LOAD_CYCLES = 560,
  parameter int         RST_CYCLES  = 24,
  parameter logic [7:0] ID_MAKER    = 8'hA7,
  parameter logic [7:0] ID_DEVICE   = 8'h3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        cle,
  input  logic        ale,
  input  logic        we_n,
  input  logic        re_n,
  input  logic [7:0]  io_in,
  output logic [7:0]  io_out,
  output logic        io_oe,
  output logic        rdy,
  output logic        arr_en,
  output logic [PAGE_BITS+BLOCK_BITS+$clog2(PAGE_BYTES)-1:0] arr_addr,
  input  logic [7:0]  arr_rdata
);
  localparam int ROW_W  = PAGE_BITS + BLOCK_BITS;
  localparam int DCOL_W = $clog2(PAGE_BYTES);
  localparam int TCOL_W = $clog2(PAGE_BYTES + SPARE_BYTES);

  logic [1:0]        rise, fall;
  logic              we_rise, re_rise;
  logic              busy, done;
  logic [7:0]        rd_data, data_byte, id_byte;
  logic [ROW_W-1:0]  load_row;
  logic [TCOL_W-1:0] col_q;
  seq_state_e        state_q;
  out_mode_e         omode_q;
  logic [1:0]        id_idx_q;

  // named events for the checker
  logic evt_load_start, evt_page_cross, evt_abort, in_reset, spare_col;

  nand_rom_edge #(.W(2)) edge_i (
    .clk(clk), .rst_n(rst_n), .pin({re_n, we_n}), .rise(rise), .fall(fall)
  );
  assign we_rise = rise[0];
  assign re_rise = rise[1];

  nand_rom_seq #(
    .PAGE_BYTES(PAGE_BYTES), .SPARE_BYTES(SPARE_BYTES), .ROW_W(ROW_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .io_in(io_in),
    .we_rise(we_rise), .re_rise(re_rise), .done(done),
    .start_load(evt_load_start), .start_rst(in_reset_start), .abort(evt_abort),
    .page_cross(evt_page_cross), .load_row(load_row), .col_q(col_q),
    .state_q(state_q), .omode_q(omode_q), .id_idx_q(id_idx_q)
  );

  logic in_reset_start;

  nand_rom_loader #(
    .PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .ARR_LAT(ARR_LAT),
    .LOAD_CYCLES(LOAD_CYCLES), .RST_CYCLES(RST_CYCLES)
  ) loader_i (
    .clk(clk), .rst_n(rst_n), .start_load(evt_load_start), .start_rst(in_reset_start),
    .abort(evt_abort), .row(load_row), .arr_en(arr_en), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata), .rd_col(col_q[DCOL_W-1:0]), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  assign in_reset  = (state_q == S_RESET);
  assign spare_col = (col_q >= TCOL_W'(PAGE_BYTES));
  assign data_byte = (state_q == S_STREAM && !spare_col) ? rd_data : 8'hFF;
  assign id_byte   = (id_idx_q == 2'd0) ? ID_MAKER :
                     (id_idx_q == 2'd1) ? ID_DEVICE : 8'hFF;

  always_comb begin
    case (omode_q)
      OM_STATUS: io_out = status_byte(!busy);
      OM_ID:     io_out = id_byte;
      default:   io_out = data_byte;
    endcase
  end

  assign io_oe = !ce_n && !re_n;
  assign rdy   = !busy;
endmodule

// File: rtl/nand_rom_chk.sv
module nand_rom_chk
  import nand_rom_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       rdy,
  input logic       io_oe,
  input logic [7:0] io_out,
  input logic [1:0] omode,
  input logic       evt_load_start,
  input logic       evt_page_cross,
  input logic       evt_abort,
  input logic       in_reset,
  input logic       spare_col
);
  p_busy_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load_start |=> !rdy);

  p_cross_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_page_cross |=> !rdy);

  p_abort_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> rdy);

  p_status_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && omode == 2'(OM_STATUS)) |->
      (io_out[7] && io_out[5:0] == 6'd0 && io_out[6] == rdy));

  p_reset_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |-> !rdy);

  p_oe_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !io_oe);

  p_spare_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && omode == 2'(OM_DATA) && spare_col) |-> (io_out == 8'hFF));
endmodule

bind nand_rom_front nand_rom_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rdy(rdy), .io_oe(io_oe),
  .io_out(io_out), .omode(omode_q), .evt_load_start(evt_load_start),
  .evt_page_cross(evt_page_cross), .evt_abort(evt_abort),
  .in_reset(in_reset), .spare_col(spare_col)
);

// File: tb/nand_rom_front_tb_top.sv
module nand_rom_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;
  localparam int LOAD_BUSY  = 560;
  localparam int RST_BUSY   = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0]  io_in = 8'h00;
  logic [7:0]  io_out;
  logic        io_oe, rdy, arr_en;
  logic [24:0] arr_addr;
  logic [7:0]  arr_rdata;
  logic [24:0] pipe_a [LAT];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_rom_front #(.ARR_LAT(LAT), .LOAD_CYCLES(560), .RST_CYCLES(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rdy(rdy),
    .arr_en(arr_en), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
  );

  function automatic logic [7:0] arr_fn(logic [24:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {7'd0, a[24]} ^ 8'h5A;
  endfunction

  // backing array model: data follows the request by LAT cycles
  always @(posedge clk) begin
    pipe_a[0] <= arr_addr;
    for (int i = 1; i < LAT; i++) pipe_a[i] <= pipe_a[i-1];
  end
  assign arr_rdata = arr_fn(pipe_a[LAT-1]);

  function automatic int exp_start(logic [7:0] cmd, logic [7:0] c);
    if (cmd == 8'h01) return 256 + int'(c);
    if (cmd == 8'h50) return 512 + int'(c % 16);
    return int'(c);
  endfunction

  function automatic logic [7:0] exp_data(logic [15:0] row, int col);
    if (col >= 512) return 8'hFF;
    return arr_fn({row, 9'(col)});
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_byte(logic is_cmd, logic [7:0] b);
    cle = is_cmd; ale = !is_cmd; io_in = b; we_n = 1'b0;
    cyc(2);
    we_n = 1'b1;
    cyc(1);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b, output logic oe);
    re_n = 1'b0;
    cyc(2);
    b = io_out; oe = io_oe;
    re_n = 1'b1;
    cyc(1);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy && n < 5000) begin n++; cyc(1); end
  endtask

  task automatic issue_read(logic [7:0] cmd, logic [7:0] c, logic [15:0] row);
    wr_byte(1'b1, cmd);
    wr_byte(1'b0, c);
    wr_byte(1'b0, row[7:0]);
    wr_byte(1'b0, row[15:8]);
  endtask

  task automatic read_and_check(string req, logic [15:0] row, int col, int n);
    logic [7:0] b; logic oe;
    for (int k = 0; k < n; k++) begin
      rd(b, oe);
      chk(req, {8'd0, b}, {8'd0, exp_data(row, col + k)});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b; logic oe; int n;
    int unsigned seed;
    seed = $urandom(32'd4711);
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R13 rdy after reset", {15'd0, rdy}, 16'd1);
    chk("R13 oe after reset", {15'd0, io_oe}, 16'd0);

    ce_n = 1'b0;
    cyc(1);
    chk("R11 oe with re_n high", {15'd0, io_oe}, 16'd0);

    // ID read
    wr_byte(1'b1, 8'h90);
    rd(b, oe); chk("R9 maker", {8'd0, b}, 16'h00A7);
    chk("R11 oe during read", {15'd0, oe}, 16'd1);
    rd(b, oe); chk("R9 device", {8'd0, b}, 16'h003C);
    rd(b, oe); chk("R9 past id", {8'd0, b}, 16'h00FF);

    wr_byte(1'b1, 8'h70);
    rd(b, oe); chk("R8 status ready", {8'd0, b}, 16'h00C0);

    // R1 R3 R4: directed 00h read
    issue_read(8'h00, 8'd5, 16'h1234);
    chk("R3 busy right after address", {15'd0, rdy}, 16'd0);
    wait_rdy(n);
    chk("R3 busy length", 16'(n), 16'(LOAD_BUSY));
    read_and_check("R4 R1 stream 00h", 16'h1234, 5, 8);

    // R12: program codes ignored mid stream
    wr_byte(1'b1, 8'h80);
    wr_byte(1'b1, 8'h10);
    read_and_check("R12 stream resumes", 16'h1234, 13, 2);

    // R7: abort during load
    issue_read(8'h00, 8'd0, 16'h0042);
    cyc(10);
    ce_n = 1'b1;
    cyc(1);
    chk("R7 ready after abort", {15'd0, rdy}, 16'd1);
    // R1: command ignored while ce_n high
    wr_byte(1'b1, 8'h70);
    ce_n = 1'b0;
    cyc(1);
    rd(b, oe); chk("R7 R1 idle read FF", {8'd0, b}, 16'h00FF);

    // R2: 01h and 50h start columns
    issue_read(8'h01, 8'd10, 16'h0ABC);
    wait_rdy(n);
    read_and_check("R2 01h start", 16'h0ABC, exp_start(8'h01, 8'd10), 4);
    issue_read(8'h50, 8'h23, 16'h0ABC);
    wait_rdy(n);
    read_and_check("R2 R5 50h spare bytes", 16'h0ABC, exp_start(8'h50, 8'h23), 4);

    // R8: status during load
    issue_read(8'h00, 8'd0, 16'h7777);
    cyc(3);
    wr_byte(1'b1, 8'h70);
    rd(b, oe); chk("R8 status busy", {8'd0, b}, 16'h0080);
    wait_rdy(n);
    rd(b, oe); chk("R8 status ready after load", {8'd0, b}, 16'h00C0);

    // R6: crossing from 01h read
    issue_read(8'h01, 8'd200, 16'h0300);
    wait_rdy(n);
    read_and_check("R6 R5 tail of page", 16'h0300, 456, 72);
    chk("R6 busy at cross", {15'd0, rdy}, 16'd0);
    wait_rdy(n);
    chk("R6 cross busy length", 16'(n), 16'(LOAD_BUSY));
    read_and_check("R6 next row col 0", 16'h0301, 0, 4);

    // R6: crossing from 50h read
    issue_read(8'h50, 8'd12, 16'h0500);
    wait_rdy(n);
    read_and_check("R6 R5 spare tail", 16'h0500, 524, 4);
    chk("R6 busy at spare cross", {15'd0, rdy}, 16'd0);
    wait_rdy(n);
    read_and_check("R6 restart at 512", 16'h0501, 512, 2);

    // R10: reset during load
    issue_read(8'h00, 8'd0, 16'h0600);
    cyc(5);
    wr_byte(1'b1, 8'hFF);
    wait_rdy(n);
    chk("R10 reset busy length", 16'(n), 16'(RST_BUSY));
    rd(b, oe); chk("R10 idle after reset", {8'd0, b}, 16'h00FF);

    // random reads
    for (int it = 0; it < 6; it++) begin
      logic [7:0] cmd, c; logic [15:0] row; int sel;
      sel = int'($urandom % 3);
      cmd = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h01 : 8'h50;
      c   = 8'($urandom);
      row = 16'($urandom);
      issue_read(cmd, c, row);
      wait_rdy(n);
      chk("R3 random busy length", 16'(n), 16'(LOAD_BUSY));
      read_and_check("R2 R4 random stream", row, exp_start(cmd, c), 6);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule